// File: doc/BRIEF.md
# I2C Target Address Matcher

This block lets a chip answer as a target on a two-wire I2C bus. Both bus lines are brought into the system clock domain through flop chains. Bus conditions are derived from those synchronised copies: a falling SDA while SCL is high opens a transfer, and a rising SDA while SCL is high closes it. After each opening condition the block shifts in the address byte, or the header and low byte in ten-bit mode. It compares them with an address that software programs, and pulls SDA low in the acknowledge slot when the address belongs to it.

Once addressed, the block either collects bytes from the controller or serves bytes to it, depending on the direction bit. A byte-wide port carries received bytes to the host with a one-cycle valid strobe. On the transmit side, the host presents the next byte and the block signals each time it has taken one. A general-call response to the all-zero address can be switched on. Acknowledge of received data bytes can be switched off, so that the controller sees a NACK.

Top module: `i2c_target_matcher`

## Requirements
- R1: While reset is asserted and right after it, `sda_pull` is 0 and every strobe output (`addr_match`, `general_call_hit`, `rx_byte_valid`, `tx_byte_request`) is 0.
- R2: In seven-bit mode (`cfg_ten_bit`=0), a first byte whose bits [7:1] equal `cfg_own_addr[6:0]` is acknowledged: `sda_pull`=1 during the ninth SCL pulse, and `addr_match` pulses. Any other address gets SDA released in the ninth pulse, and later bytes are ignored (no ACK, no strobes) until the next START.
- R3: After an address match, `dir` equals bit 0 of the address byte (1 = controller reads from the block, 0 = controller writes).
- R4: With `cfg_gc_en`=1, a first byte of 0x00 is acknowledged whatever the own address is. It pulses `general_call_hit` instead of `addr_match` and sets `dir`=0. With `cfg_gc_en`=0, that byte is not acknowledged.
- R5: In ten-bit mode, a header byte equal to {11110, `cfg_own_addr[9:8]`, 0} is acknowledged, and then a second byte equal to `cfg_own_addr[7:0]` is acknowledged with an `addr_match` pulse. A mismatch in either byte gets a NACK.
- R6: In ten-bit mode, a header of the form {11110, `cfg_own_addr[9:8]`, 1} is acknowledged with `addr_match` and `dir`=1 only after a repeated START that follows a complete ten-bit write match. After a STOP the same header gets a NACK.
- R7: Bytes written by the controller are assembled MSB first. Each appears on `rx_data` with exactly one `rx_byte_valid` pulse, after its eighth bit.
- R8: With `cfg_data_ack_en`=1, received data bytes are acknowledged. With 0, SDA stays released in their ninth pulse, while the byte is still delivered on `rx_data`.
- R9: In a read, `tx_data` is latched at the start of each byte and sent MSB first, and each latch gives one `tx_byte_request` pulse. A controller NACK ends the read and leaves SDA released.
- R10: A STOP at any point, including mid-byte, returns the block to idle. Bytes clocked afterwards without a START are ignored.
- R11: A repeated START at any point, including mid-byte, restarts address capture. Any partial byte is discarded.
- R12: Every strobe output is high for exactly one system clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| cfg_own_addr | input | 10 | Own address; bits [6:0] used in seven-bit mode |
| cfg_ten_bit | input | 1 | 1 = ten-bit addressing |
| cfg_gc_en | input | 1 | 1 = respond to the general-call address |
| cfg_data_ack_en | input | 1 | 1 = acknowledge received data bytes |
| tx_data | input | 8 | Next byte to send in a read |
| rx_data | output | 8 | Last received data byte |
| addr_match | output | 1 | Strobe: own address matched |
| general_call_hit | output | 1 | Strobe: general call accepted |
| dir | output | 1 | Direction of current transfer, 1 = read |
| rx_byte_valid | output | 1 | Strobe: `rx_data` holds a new byte |
| tx_byte_request | output | 1 | Strobe: `tx_data` was taken, present the next byte |

## Verification
The assertions watch, on every cycle, properties that are local in time. Each match strobe must coincide with SDA being pulled. Received-byte strobes may only occur in a write and transmit strobes only in a read. Every strobe must last a single cycle, and the outputs must stay quiet under reset. Only the bench scenarios can show whether the right addresses are accepted in each mode, including the header-then-low-byte order and the armed ten-bit read. They also show that bytes arrive intact and in order, that STOP and repeated START cut a byte short correctly, and that ignored traffic really goes unacknowledged on the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int OWN_W  = 10;
  localparam int BYTE_W = 8;
  localparam int HI_W   = OWN_W - BYTE_W;
  localparam logic [4:0] TEN_MARK = 5'b11110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HACK,
    ST_ADDR2,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_prev, sda_prev;
  logic scl_now;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_chain
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
          end else begin
            scl_chain[0] <= scl_in;
            sda_chain[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_now = scl_chain[STAGES-1];
  assign sda_s   = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              ten_bit,
  input  logic              gc_en,
  input  logic              ten_armed,
  output logic              gc_hit,
  output logic              own7_hit,
  output logic              hdr_wr_hit,
  output logic              hdr_rd_hit,
  output logic              low_hit
);
  logic hdr_form;

  assign hdr_form   = (rx_byte[BYTE_W-1 -: 5] == TEN_MARK) &&
                      (rx_byte[HI_W:1] == own_addr[OWN_W-1 -: HI_W]);
  assign gc_hit     = gc_en && (rx_byte == '0);
  assign own7_hit   = !ten_bit && (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
  assign hdr_wr_hit = ten_bit && hdr_form && !rx_byte[0];
  assign hdr_rd_hit = ten_bit && hdr_form && rx_byte[0] && ten_armed;
  assign low_hit    = (rx_byte == own_addr[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              ten_bit,
  input  logic              gc_en,
  input  logic              data_ack_en,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_pull,
  output logic              dir,
  output logic [BYTE_W-1:0] rx_data,
  output logic              addr_match,
  output logic              gc_strobe,
  output logic              rx_strobe,
  output logic              tx_strobe
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  tgt_state_e        state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic pull_q, pull_d;
  logic rw_q, rw_d;
  logic armed_q, armed_d;
  logic nack_q, nack_d;
  logic am_q, am_d, gc_q, gc_d, rxv_q, rxv_d, txr_q, txr_d;

  logic gc_hit, own7_hit, hdr_wr_hit, hdr_rd_hit, low_hit;

  i2c_addr_cmp u_cmp (
    .rx_byte   (sh_q),
    .own_addr  (own_addr),
    .ten_bit   (ten_bit),
    .gc_en     (gc_en),
    .ten_armed (armed_q),
    .gc_hit    (gc_hit),
    .own7_hit  (own7_hit),
    .hdr_wr_hit(hdr_wr_hit),
    .hdr_rd_hit(hdr_rd_hit),
    .low_hit   (low_hit)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    rxd_d   = rxd_q;
    cnt_d   = cnt_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    armed_d = armed_q;
    nack_d  = nack_q;
    am_d    = 1'b0;
    gc_d    = 1'b0;
    rxv_d   = 1'b0;
    txr_d   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      pull_d  = 1'b0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_ADDR, ST_ADDR2, ST_RX: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + ONE;
            if (state_q == ST_RX && cnt_q == FULL - ONE) begin
              rxd_d = {sh_q[BYTE_W-2:0], sda_s};
              rxv_d = 1'b1;
            end
          end else if (scl_fall && cnt_q == FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (gc_hit) begin
                pull_d = 1'b1; rw_d = 1'b0; gc_d = 1'b1; state_d = ST_AACK;
              end else if (own7_hit) begin
                pull_d = 1'b1; rw_d = sh_q[0]; am_d = 1'b1; state_d = ST_AACK;
              end else if (hdr_wr_hit) begin
                pull_d = 1'b1; armed_d = 1'b0; state_d = ST_HACK;
              end else if (hdr_rd_hit) begin
                pull_d = 1'b1; rw_d = 1'b1; am_d = 1'b1; state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_ADDR2) begin
              if (low_hit) begin
                pull_d = 1'b1; rw_d = 1'b0; am_d = 1'b1; armed_d = 1'b1;
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              pull_d  = data_ack_en;
              state_d = ST_RACK;
            end
          end
        end
        ST_HACK, ST_RACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = (state_q == ST_HACK) ? ST_ADDR2 : ST_RX;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = tx_data;
              pull_d  = ~tx_data[BYTE_W-1];
              txr_d   = 1'b1;
              state_d = ST_TX;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != FULL) begin
            cnt_d = cnt_q + ONE;
          end else if (scl_fall && cnt_q == FULL) begin
            pull_d  = 1'b0;
            state_d = ST_TACK;
          end else if (scl_fall && cnt_q != '0) begin
            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
            pull_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (nack_q) begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end else begin
              sh_d    = tx_data;
              pull_d  = ~tx_data[BYTE_W-1];
              txr_d   = 1'b1;
              state_d = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      rxd_q   <= '0;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      armed_q <= 1'b0;
      nack_q  <= 1'b0;
      am_q    <= 1'b0;
      gc_q    <= 1'b0;
      rxv_q   <= 1'b0;
      txr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      rxd_q   <= rxd_d;
      cnt_q   <= cnt_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      armed_q <= armed_d;
      nack_q  <= nack_d;
      am_q    <= am_d;
      gc_q    <= gc_d;
      rxv_q   <= rxv_d;
      txr_q   <= txr_d;
    end
  end

  assign sda_pull   = pull_q;
  assign dir        = rw_q;
  assign rx_data    = rxd_q;
  assign addr_match = am_q;
  assign gc_strobe  = gc_q;
  assign rx_strobe  = rxv_q;
  assign tx_strobe  = txr_q;
endmodule

// File: rtl/i2c_target_matcher.sv
module i2c_target_matcher
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [OWN_W-1:0]  cfg_own_addr,
  input  logic              cfg_ten_bit,
  input  logic              cfg_gc_en,
  input  logic              cfg_data_ack_en,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  output logic              addr_match,
  output logic              general_call_hit,
  output logic              dir,
  output logic              rx_byte_valid,
  output logic              tx_byte_request
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .own_addr   (cfg_own_addr),
    .ten_bit    (cfg_ten_bit),
    .gc_en      (cfg_gc_en),
    .data_ack_en(cfg_data_ack_en),
    .tx_data    (tx_data),
    .sda_pull   (sda_pull),
    .dir        (dir),
    .rx_data    (rx_data),
    .addr_match (addr_match),
    .gc_strobe  (general_call_hit),
    .rx_strobe  (rx_byte_valid),
    .tx_strobe  (tx_byte_request)
  );
endmodule

// File: rtl/i2c_target_matcher_chk.sv
module i2c_target_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic dir,
  input logic addr_match,
  input logic general_call_hit,
  input logic rx_byte_valid,
  input logic tx_byte_request
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!sda_pull && !addr_match && !general_call_hit &&
                                !rx_byte_valid && !tx_byte_request);
    end
  end

  p_match_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> sda_pull);

  p_gc_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    general_call_hit |-> (sda_pull && !addr_match && !dir));

  p_rx_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> !dir);

  p_tx_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_request |-> dir);

  p_am_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !addr_match);

  p_gc_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    general_call_hit |=> !general_call_hit);

  p_rx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |=> !rx_byte_valid);

  p_tx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_request |=> !tx_byte_request);
endmodule

bind i2c_target_matcher i2c_target_matcher_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sda_pull        (sda_pull),
  .dir             (dir),
  .addr_match      (addr_match),
  .general_call_hit(general_call_hit),
  .rx_byte_valid   (rx_byte_valid),
  .tx_byte_request (tx_byte_request)
);

// File: tb/i2c_target_matcher_bench.sv
`timescale 1ns/1ps
module i2c_target_matcher_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic bus_sda;
  logic sda_pull;
  logic [9:0] cfg_own_addr;
  logic cfg_ten_bit, cfg_gc_en, cfg_data_ack_en;
  logic [7:0] tx_data;
  logic [7:0] rx_data;
  logic addr_match, general_call_hit, dir, rx_byte_valid, tx_byte_request;

  int n_chk = 0;
  int n_err = 0;
  int am_cnt = 0, gc_cnt = 0, txr_cnt = 0;
  bit done = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_src[$];

  always #10 clk = ~clk;

  assign bus_sda = m_sda & ~sda_pull;

  i2c_target_matcher u_i2c_target_matcher (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_in          (m_scl),
    .sda_in          (bus_sda),
    .sda_pull        (sda_pull),
    .cfg_own_addr    (cfg_own_addr),
    .cfg_ten_bit     (cfg_ten_bit),
    .cfg_gc_en       (cfg_gc_en),
    .cfg_data_ack_en (cfg_data_ack_en),
    .tx_data         (tx_data),
    .rx_data         (rx_data),
    .addr_match      (addr_match),
    .general_call_hit(general_call_hit),
    .dir             (dir),
    .rx_byte_valid   (rx_byte_valid),
    .tx_byte_request (tx_byte_request)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for received bytes, strobe counters, transmit supply
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_byte_valid) begin
        if (exp_rx.size() == 0) begin
          check("R7 unexpected rx byte", {24'h0, rx_data}, 32'hFFFF_FFFF);
        end else begin
          check("R7 rx byte", {24'h0, rx_data}, {24'h0, exp_rx.pop_front()});
        end
      end
      if (addr_match) am_cnt++;
      if (general_call_hit) gc_cnt++;
      if (tx_byte_request) begin
        txr_cnt++;
        if (tx_src.size() > 0) void'(tx_src.pop_front());
      end
    end
    tx_data <= (tx_src.size() > 0) ? tx_src[0] : 8'hFF;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_rstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    r = bus_sda; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_write(input logic [7:0] b, input bit expect_rx, output bit acked);
    logic r;
    if (expect_rx) exp_rx.push_back(b);
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic m_read(input bit give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      b[i] = r;
    end
    m_bit(!give_ack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10 actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit ack;
    int am0, gc0, tx0;
    logic [7:0] rb;
    logic r;

    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    cfg_own_addr = 10'h05A;
    cfg_ten_bit = 1'b0;
    cfg_gc_en = 1'b0;
    cfg_data_ack_en = 1'b1;
    tick(5);
    check("R1 reset sda_pull", sda_pull, 0);
    check("R1 reset strobes", {addr_match, general_call_hit, rx_byte_valid, tx_byte_request}, 0);
    rst_n = 1'b1;
    tick(5);
    check("R1 after reset sda_pull", sda_pull, 0);

    // seven-bit write
    am0 = am_cnt;
    m_start();
    m_write(8'hB4, 0, ack);
    check("R2 own address ack", ack, 1);
    check("R2 addr_match pulse", am_cnt - am0, 1);
    check("R3 dir write", dir, 0);
    m_write(8'h3C, 1, ack);
    check("R8 data ack on", ack, 1);
    m_write(8'hA5, 1, ack);
    check("R7 second byte ack", ack, 1);
    m_stop();

    // seven-bit mismatch
    am0 = am_cnt;
    m_start();
    m_write(8'hB6, 0, ack);
    check("R2 foreign address nack", ack, 0);
    m_write(8'h11, 0, ack);
    check("R2 ignored byte nack", ack, 0);
    check("R2 no addr_match", am_cnt - am0, 0);
    m_stop();

    // general call
    m_start();
    m_write(8'h00, 0, ack);
    check("R4 gc disabled nack", ack, 0);
    m_stop();
    cfg_gc_en = 1'b1;
    am0 = am_cnt; gc0 = gc_cnt;
    m_start();
    m_write(8'h00, 0, ack);
    check("R4 gc enabled ack", ack, 1);
    check("R4 gc pulse", gc_cnt - gc0, 1);
    check("R4 no addr_match on gc", am_cnt - am0, 0);
    check("R4 gc dir", dir, 0);
    m_write(8'h77, 1, ack);
    check("R4 gc data ack", ack, 1);
    m_stop();
    cfg_gc_en = 1'b0;

    // data ack disabled
    cfg_data_ack_en = 1'b0;
    m_start();
    m_write(8'hB4, 0, ack);
    check("R8 address still acked", ack, 1);
    m_write(8'h81, 1, ack);
    check("R8 data nack when disabled", ack, 0);
    m_stop();
    cfg_data_ack_en = 1'b1;

    // seven-bit read
    tx_src.push_back(8'hC3);
    tx_src.push_back(8'h5E);
    tick(2);
    tx0 = txr_cnt;
    m_start();
    m_write(8'hB5, 0, ack);
    check("R2 read address ack", ack, 1);
    check("R3 dir read", dir, 1);
    m_read(1, rb);
    check("R9 first tx byte", rb, 8'hC3);
    m_read(0, rb);
    check("R9 second tx byte", rb, 8'h5E);
    tick(Q);
    check("R9 released after nack", sda_pull, 0);
    check("R9 tx requests", txr_cnt - tx0, 2);
    m_stop();

    // ten-bit write
    cfg_ten_bit = 1'b1;
    cfg_own_addr = 10'h2C7;
    am0 = am_cnt;
    m_start();
    m_write(8'hF4, 0, ack);
    check("R5 header ack", ack, 1);
    check("R5 no match on header alone", am_cnt - am0, 0);
    m_write(8'hC7, 0, ack);
    check("R5 low byte ack", ack, 1);
    check("R5 addr_match after low byte", am_cnt - am0, 1);
    m_write(8'h42, 1, ack);
    check("R5 data ack", ack, 1);
    m_stop();

    m_start();
    m_write(8'hF4, 0, ack);
    m_write(8'hC6, 0, ack);
    check("R5 low byte mismatch nack", ack, 0);
    m_stop();
    m_start();
    m_write(8'hF2, 0, ack);
    check("R5 header mismatch nack", ack, 0);
    m_stop();

    // ten-bit read after repeated start
    tx_src.push_back(8'h99);
    tick(2);
    m_start();
    m_write(8'hF4, 0, ack);
    m_write(8'hC7, 0, ack);
    m_rstart();
    am0 = am_cnt;
    m_write(8'hF5, 0, ack);
    check("R6 read header ack", ack, 1);
    check("R6 read header match", am_cnt - am0, 1);
    check("R6 dir read", dir, 1);
    m_read(0, rb);
    check("R6 ten-bit read byte", rb, 8'h99);
    m_stop();

    m_start();
    m_write(8'hF5, 0, ack);
    check("R6 unarmed read header nack", ack, 0);
    m_stop();

    // STOP mid-byte
    cfg_ten_bit = 1'b0;
    cfg_own_addr = 10'h05A;
    m_start();
    m_write(8'hB4, 0, ack);
    for (int i = 0; i < 4; i++) m_bit(1'b0, r);
    m_stop();
    am0 = am_cnt;
    m_scl = 1'b0; tick(Q);
    m_write(8'hB4, 0, ack);
    check("R10 no ack without start", ack, 0);
    check("R10 no match without start", am_cnt - am0, 0);
    m_stop();
    m_start();
    m_write(8'hB4, 0, ack);
    check("R10 normal after stop", ack, 1);
    m_stop();

    // repeated START mid-byte
    tx_src.push_back(8'h6B);
    tick(2);
    m_start();
    m_write(8'hB4, 0, ack);
    for (int i = 0; i < 3; i++) m_bit(1'b1, r);
    m_rstart();
    m_write(8'hB5, 0, ack);
    check("R11 address after repeated start", ack, 1);
    check("R11 dir after repeated start", dir, 1);
    m_read(0, rb);
    check("R11 read byte", rb, 8'h6B);
    m_stop();

    tick(20);
    check("R7 all bytes delivered", exp_rx.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule